// File: doc/BRIEF.md
# Vertical-Blank Framebuffer Swapper

This block runs double buffering between a renderer and a display that sit on unrelated clocks. There are two framebuffers in memory. At any time the renderer draws into one of them and the display scans out the other. The block produces both base addresses, one in each clock domain. It decides when the two buffers change roles.

When the renderer finishes a frame, it pulses `r_frame_done` and then stalls. The event crosses into the display domain as a toggle and is held there as a pending frame. The exchange happens only when a frame is pending and the display reports vertical blanking, so the picture never changes mid-scan. The display then reads the freshly drawn buffer. An acknowledgement toggle returns to the render domain. That flips the write buffer, clears the stall, and gives a one-cycle `r_go` so the renderer can begin the next frame. Only one finished frame can wait at a time.

The block has no data stream of its own. Every pin is a plain control or status signal, and no back-pressure applies. `d_vblank` is taken to be synchronous to `d_clk`. `r_frame_done` is taken to be synchronous to `r_clk`.

Top module: `fb_vsync_swapper`

## Requirements
- R1: After reset, `r_wr_base` equals BASE_B, `d_rd_base` equals BASE_A, and `r_stall` and `r_go` are low.
- R2: A one-cycle `r_frame_done` while not stalled raises `r_stall` on the next `r_clk` edge. `r_stall` stays high until the swap is acknowledged.
- R3: While `d_vblank` is low, `d_rd_base` never changes, however long a frame has been pending.
- R4: When a frame is pending and `d_vblank` is high, `d_rd_base` switches to the buffer the renderer just finished, which is the value `r_wr_base` held during that frame.
- R5: After a swap, `r_go` is high for exactly one `r_clk` cycle. On that same edge `r_stall` falls and `r_wr_base` switches to the other buffer. Once the renderer runs again, `r_wr_base` and `d_rd_base` differ.
- R6: An `r_frame_done` pulse seen while `r_stall` is high has no effect. It causes no extra swap and no extra `r_go`.
- R7: A blanking interval with no pending frame leaves `d_rd_base` unchanged and produces no `r_go`.
- R8: If the frame completes while `d_vblank` is already high, the swap still happens inside that same blanking interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| r_clk | input | 1 | Render-domain clock |
| r_rst_n | input | 1 | Render-domain reset, active low, asynchronous |
| r_frame_done | input | 1 | One-cycle pulse: the renderer has finished the current frame |
| r_stall | output | 1 | High while the renderer must wait for a swap |
| r_go | output | 1 | One-cycle pulse: the renderer may start the next frame |
| r_wr_base | output | ADDR_W | Base address of the buffer the renderer writes |
| d_clk | input | 1 | Display-domain clock |
| d_rst_n | input | 1 | Display-domain reset, active low, asynchronous |
| d_vblank | input | 1 | High during the display's vertical blanking interval |
| d_rd_base | output | ADDR_W | Base address of the buffer the display reads |

## Verification
A vector table drives a fixed sequence of rounds. Each round either pulses frame completion, opens a blanking window, or does both. The sequence separates four cases:
- a frame that is pending but not yet in blanking, which must not swap;
- a frame-done pulse during a stall, which must be ignored;
- a blanking window with nothing pending, which must keep the current buffer;
- the true combination, which must swap exactly once.

A directed case raises blanking before the frame completes, to confirm the swap still lands inside that window. A monitor counts `r_go` pulses and checks their width against the number of swaps the model predicts.

// File: rtl/fbswap_pkg.sv
package fbswap_pkg;
  typedef enum logic {
    RS_DRAW = 1'b0,
    RS_WAIT = 1'b1
  } rstate_e;
endpackage

// File: rtl/fbs_toggle_xfer.sv
module fbs_toggle_xfer #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_pulse,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);
  logic              src_tog;
  logic [STAGES:0]   chain;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) src_tog <= 1'b0;
    else if (src_pulse) src_tog <= ~src_tog;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) chain <= '0;
    else chain <= {chain[STAGES-1:0], src_tog};
  end

  assign dst_pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/fbs_render_ctrl.sv
module fbs_render_ctrl
  import fbswap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic ack_pulse,
  output logic req_pulse,
  output logic sel,
  output logic stall,
  output logic go
);
  rstate_e state;

  assign req_pulse = frame_done && (state == RS_DRAW);
  assign stall     = (state == RS_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RS_DRAW;
      sel   <= 1'b1;
      go    <= 1'b0;
    end else begin
      go <= 1'b0;
      case (state)
        RS_DRAW: if (frame_done) state <= RS_WAIT;
        RS_WAIT: if (ack_pulse) begin
          state <= RS_DRAW;
          sel   <= ~sel;
          go    <= 1'b1;
        end
        default: state <= RS_DRAW;
      endcase
    end
  end

  // R2: the stall holds until an acknowledgement arrives
  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ack_pulse) |=> stall);
  // R5: go lasts a single cycle
  a_r5_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  // R5: the write buffer flips exactly when go is issued
  a_r5_sel_flip: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (sel != $past(sel)));
  // R6: a request is only launched outside a stall
  a_r6_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_pulse);
endmodule

// File: rtl/fbs_display_ctrl.sv
module fbs_display_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_pulse,
  input  logic vblank,
  output logic sel,
  output logic ack_pulse
);
  logic pending;
  logic swap;

  assign swap = pending && vblank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      sel       <= 1'b0;
      ack_pulse <= 1'b0;
    end else begin
      ack_pulse <= swap;
      if (swap) begin
        sel     <= ~sel;
        pending <= 1'b0;
      end else if (req_pulse) begin
        pending <= 1'b1;
      end
    end
  end

  // R3: the read buffer cannot move outside blanking
  a_r3_hold_outside_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank |=> $stable(sel));
  // R7: the read buffer cannot move without a pending frame
  a_r7_no_swap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> $stable(sel));
endmodule

// File: rtl/fb_vsync_swapper.sv
module fb_vsync_swapper #(
  parameter int              ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_A    = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] BASE_B    = 32'h0020_0000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              r_clk,
  input  logic              r_rst_n,
  input  logic              r_frame_done,
  output logic              r_stall,
  output logic              r_go,
  output logic [ADDR_W-1:0] r_wr_base,
  input  logic              d_clk,
  input  logic              d_rst_n,
  input  logic              d_vblank,
  output logic [ADDR_W-1:0] d_rd_base
);
  logic r_req, r_ack, r_sel;
  logic d_req, d_ack, d_sel;

  fbs_render_ctrl u_rctl (
    .clk(r_clk), .rst_n(r_rst_n), .frame_done(r_frame_done),
    .ack_pulse(r_ack), .req_pulse(r_req), .sel(r_sel),
    .stall(r_stall), .go(r_go)
  );

  fbs_toggle_xfer #(.STAGES(SYNC_STAGES)) u_req_xfer (
    .src_clk(r_clk), .src_rst_n(r_rst_n), .src_pulse(r_req),
    .dst_clk(d_clk), .dst_rst_n(d_rst_n), .dst_pulse(d_req)
  );

  fbs_display_ctrl u_dctl (
    .clk(d_clk), .rst_n(d_rst_n), .req_pulse(d_req),
    .vblank(d_vblank), .sel(d_sel), .ack_pulse(d_ack)
  );

  fbs_toggle_xfer #(.STAGES(SYNC_STAGES)) u_ack_xfer (
    .src_clk(d_clk), .src_rst_n(d_rst_n), .src_pulse(d_ack),
    .dst_clk(r_clk), .dst_rst_n(r_rst_n), .dst_pulse(r_ack)
  );

  assign r_wr_base = r_sel ? BASE_B : BASE_A;
  assign d_rd_base = d_sel ? BASE_B : BASE_A;
endmodule

// File: tb/test_fb_vsync_swapper.sv
module test_fb_vsync_swapper;
  localparam logic [31:0] BA = 32'h0000_0000;
  localparam logic [31:0] BB = 32'h0020_0000;

  logic r_clk = 0, d_clk = 0, r_rst_n = 0, d_rst_n = 0;
  logic r_frame_done = 0, d_vblank = 0;
  logic r_stall, r_go;
  logic [31:0] r_wr_base, d_rd_base;

  int checks = 0, failures = 0, go_count = 0;
  bit finished = 0;
  logic go_prev = 0;

  always #4 r_clk = ~r_clk;
  always #7.5 d_clk = ~d_clk;

  fb_vsync_swapper i_fb_vsync_swapper (
    .r_clk(r_clk), .r_rst_n(r_rst_n), .r_frame_done(r_frame_done),
    .r_stall(r_stall), .r_go(r_go), .r_wr_base(r_wr_base),
    .d_clk(d_clk), .d_rst_n(d_rst_n), .d_vblank(d_vblank),
    .d_rd_base(d_rd_base)
  );

  // round table: {pulse frame_done, open blanking window}
  localparam int NV = 8;
  localparam logic [1:0] VEC [NV] = '{2'b10, 2'b00, 2'b10, 2'b01,
                                      2'b01, 2'b11, 2'b10, 2'b01};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5: monitor go pulse width and count
  always @(negedge r_clk) begin
    if (r_rst_n) begin
      if (r_go) go_count++;
      if (r_go && go_prev) begin
        checks++; failures++;
        $display("FAIL R5 go width actual=2+ expected=1");
      end
      go_prev <= r_go;
    end
  end

  task automatic pulse_frame();
    @(negedge r_clk); r_frame_done = 1;
    @(negedge r_clk); r_frame_done = 0;
  endtask

  task automatic blank_window();
    @(negedge d_clk); d_vblank = 1;
    repeat (6) @(negedge d_clk);
    d_vblank = 0;
  endtask

  initial begin
    bit dsel = 0, rsel = 1, pend = 0;
    int swaps = 0;
    repeat (3) @(negedge d_clk);
    // R1: reset state
    check("R1 wr_base", r_wr_base, BB);
    check("R1 rd_base", d_rd_base, BA);
    check("R1 stall", {31'b0, r_stall}, 32'd0);
    check("R1 go", {31'b0, r_go}, 32'd0);
    @(negedge r_clk); r_rst_n = 1;
    @(negedge d_clk); d_rst_n = 1;
    repeat (4) @(negedge r_clk);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][1]) begin
        pulse_frame();
        if (!pend) pend = 1;   // R6: ignored while stalled
        @(negedge r_clk);
        check("R2 stall after frame_done", {31'b0, r_stall}, {31'b0, pend});
        repeat (20) @(negedge d_clk);
        check("R3 no swap outside blanking", d_rd_base, dsel ? BB : BA);
      end
      if (VEC[i][0]) begin
        blank_window();
        if (pend) begin   // R4 swap; R7 otherwise
          dsel = ~dsel; rsel = ~rsel; pend = 0; swaps++;
        end
      end
      repeat (30) @(negedge r_clk);
      check("R4 R7 rd_base", d_rd_base, dsel ? BB : BA);
      check("R5 wr_base", r_wr_base, rsel ? BB : BA);
      check("R6 stall", {31'b0, r_stall}, {31'b0, pend});
    end

    // R8: frame completes while blanking already open
    @(negedge d_clk); d_vblank = 1;
    repeat (3) @(negedge d_clk);
    pulse_frame();
    repeat (20) @(negedge d_clk);
    dsel = ~dsel; rsel = ~rsel; swaps++;
    check("R8 swap inside open blanking", d_rd_base, dsel ? BB : BA);
    check("R8 vblank still high", {31'b0, d_vblank}, 32'd1);
    repeat (10) @(negedge r_clk);
    check("R8 R5 wr_base", r_wr_base, rsel ? BB : BA);
    check("R5 bases differ", {31'b0, r_wr_base != d_rd_base}, 32'd1);
    @(negedge d_clk); d_vblank = 0;
    repeat (5) @(negedge r_clk);
    check("R5 R6 R7 go count", go_count, swaps);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule